// File: doc/BRIEF.md
# Gated generic clock generator

This block produces one generic clock for peripherals that need a particular frequency. It picks one of several source clocks, and either passes that source straight through or divides it by an even ratio between 2 and 512. The output runs only while a software enable is set and the sleep controller is not holding peripheral clocks off. To give independent channels, place several instances side by side.

All logic runs on one fast sampling clock. Each source arrives as a level that this clock oversamples. A rising edge of the selected level counts as one source cycle. The output is a registered level. Whenever the channel starts or stops, the output is low at that moment, so it never emits a truncated high pulse. The source choice and the mode (pass or divide) are captured only when the channel starts. The divide value is read live.

Top module: `gclk_gen`

## Requirements
- R1: While reset is asserted, and after it until the channel is enabled, `gclk_o` is 0.
- R2: With `cfg_div_en_i` = 0 at start, a running channel drives `gclk_o` to the level of the selected source one sampling clock later.
- R3: With `cfg_div_en_i` = 1 and an 8-bit divide field D, every high phase and every low phase of `gclk_o` lasts exactly D+1 rising edges of the selected source. The ratio is 2*(D+1) and the duty cycle is 50%.
- R4: D = 255 gives the largest ratio, 512, with phases of 256 source rising edges each.
- R5: While `sleep_off_i` = 1, the channel stops at the next low phase and `gclk_o` stays 0. When `sleep_off_i` returns to 0, the output resumes.
- R6: Starting and stopping happen only while `gclk_o` is 0. Clearing the enable during a high phase leaves that high phase at its full length.
- R7: A change of `cfg_sel_i` while the channel runs has no effect on `gclk_o`. The new source is used only after the channel has stopped and started again.
- R8: The divide counter is cleared when the channel stops. After a restart, the first rise of `gclk_o` comes exactly D+1 source rising edges after the start.
- R9: With `cfg_en_i` = 0, `gclk_o` stays 0 however the sources toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than every source |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_lvl_i | input | N_SRC | Source clock levels, one bit per source |
| cfg_en_i | input | 1 | Software enable for the channel |
| cfg_sel_i | input | SEL_W | Index of the source to use, captured at start |
| cfg_div_en_i | input | 1 | 1 selects divide mode, 0 selects pass mode; captured at start |
| cfg_div_i | input | DIV_W | Divide field D, giving ratio 2*(D+1) |
| sleep_off_i | input | 1 | Sleep-controller request that forces the channel off |
| gclk_o | output | 1 | Generated clock |

## Verification
The assertions assume that every source level is slower than half the sampling clock, so each source edge is seen, and that the source levels change away from the sampling edge. The bench drives each source from counters on the falling edge of the sampling clock: source k toggles every k+1 cycles. Configuration changes are made just after a rising edge, so each property sees clean, single-cycle transitions. Divide values in the stimulus cover the minimum, mid-range values and the maximum.

// File: rtl/gclk_pkg.sv
package gclk_pkg;

    typedef enum logic {
        MODE_PASS = 1'b0,
        MODE_DIV  = 1'b1
    } gclk_mode_e;

endpackage

// File: rtl/gclk_src_sel.sv
// Selects one oversampled source level and flags its rising edges.
module gclk_src_sel #(
    parameter int N_SRC = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_lvl_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             cur_o,
    output logic             rise_o
);

    logic [N_SRC-1:0] prev_d, prev_q;
    logic [N_SRC-1:0] edge_vec;

    always_comb begin
        prev_d = src_lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    generate
        for (genvar k = 0; k < N_SRC; k++) begin : g_edge
            assign edge_vec[k] = src_lvl_i[k] & ~prev_q[k];
        end
    endgenerate

    always_comb begin
        cur_o  = 1'b0;
        rise_o = 1'b0;
        if (32'(sel_i) < N_SRC) begin
            cur_o  = src_lvl_i[sel_i];
            rise_o = edge_vec[sel_i];
        end
    end

endmodule

// File: rtl/gclk_divider.sv
// Next-count logic for the half-period counter.
module gclk_divider #(
    parameter int DIV_W = 8
) (
    input  logic [DIV_W-1:0] cnt_i,
    input  logic [DIV_W-1:0] limit_i,
    input  logic             step_i,
    output logic [DIV_W-1:0] cnt_o,
    output logic             wrap_o
);

    always_comb begin
        wrap_o = step_i && (cnt_i >= limit_i);
        cnt_o  = cnt_i;
        if (step_i) begin
            cnt_o = wrap_o ? '0 : cnt_i + 1'b1;
        end
    end

endmodule

// File: rtl/gclk_gen.sv
module gclk_gen
    import gclk_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int DIV_W = 8,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_lvl_i,
    input  logic             cfg_en_i,
    input  logic [SEL_W-1:0] cfg_sel_i,
    input  logic             cfg_div_en_i,
    input  logic [DIV_W-1:0] cfg_div_i,
    input  logic             sleep_off_i,
    output logic             gclk_o
);

    typedef struct packed {
        logic             run;
        gclk_mode_e       mode;
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] cnt;
        logic             out;
    } state_t;

    state_t state_d, state_q;

    logic             src_cur;
    logic             src_rise;
    logic [DIV_W-1:0] cnt_next;
    logic             half_done;
    logic             want_run;

    // flat views of state for the bound checker
    logic             run_now;
    logic             div_now;
    logic [SEL_W-1:0] sel_now;
    assign run_now = state_q.run;
    assign div_now = (state_q.mode == MODE_DIV);
    assign sel_now = state_q.sel;

    gclk_src_sel #(
        .N_SRC (N_SRC),
        .SEL_W (SEL_W)
    ) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_lvl_i (src_lvl_i),
        .sel_i     (state_q.sel),
        .cur_o     (src_cur),
        .rise_o    (src_rise)
    );

    gclk_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .cnt_i   (state_q.cnt),
        .limit_i (cfg_div_i),
        .step_i  (src_rise),
        .cnt_o   (cnt_next),
        .wrap_o  (half_done)
    );

    always_comb begin
        want_run = cfg_en_i & ~sleep_off_i;
        state_d  = state_q;
        if (!state_q.run) begin
            // idle: hold output low, track configuration for the next start
            state_d.cnt  = '0;
            state_d.out  = 1'b0;
            state_d.sel  = cfg_sel_i;
            state_d.mode = cfg_div_en_i ? MODE_DIV : MODE_PASS;
            state_d.run  = want_run;
        end else if (!want_run && !state_q.out) begin
            // stop only during a low phase
            state_d.run = 1'b0;
            state_d.cnt = '0;
            state_d.out = 1'b0;
        end else if (state_q.mode == MODE_DIV) begin
            state_d.cnt = cnt_next;
            if (half_done) state_d.out = ~state_q.out;
        end else begin
            state_d.out = src_cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{run: 1'b0, mode: MODE_PASS, sel: '0, cnt: '0, out: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign gclk_o = state_q.out;

endmodule

// File: rtl/gclk_gen_chk.sv
module gclk_gen_chk #(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gclk_o,
    input logic             sleep_off_i,
    input logic             run_now,
    input logic             div_now,
    input logic [SEL_W-1:0] sel_now,
    input logic             src_rise
);

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_now |-> !gclk_o);

    // R6
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_now) |-> !$past(gclk_o));

    // R6
    stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_now) |-> !$past(gclk_o));

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_now && $past(run_now)) |-> $stable(sel_now));

    // R3
    div_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_now && $past(run_now) && div_now && $past(div_now)
         && (gclk_o != $past(gclk_o))) |-> $past(src_rise));

    // R5
    sleep_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_off_i && run_now && !gclk_o) |=> !run_now);

endmodule

bind gclk_gen gclk_gen_chk #(.SEL_W(SEL_W)) u_gclk_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gclk_o      (gclk_o),
    .sleep_off_i (sleep_off_i),
    .run_now     (run_now),
    .div_now     (div_now),
    .sel_now     (sel_now),
    .src_rise    (src_rise)
);

// File: tb/gclk_gen_bench.sv
module gclk_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;

    typedef struct packed {
        logic [1:0]  sel;
        logic [7:0]  div;
        logic [15:0] width;
    } vec_t;

    // R3: phase width in sampling cycles = (D+1) * 2*(sel+1)
    localparam vec_t VECS [6] = '{
        '{2'd0, 8'd0, 16'd2},
        '{2'd1, 8'd0, 16'd4},
        '{2'd2, 8'd3, 16'd24},
        '{2'd3, 8'd2, 16'd24},
        '{2'd1, 8'd7, 16'd32},
        '{2'd0, 8'd9, 16'd20}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          en = 1'b0;
    logic [1:0]    sel = '0;
    logic          div_en = 1'b0;
    logic [7:0]    div = '0;
    logic          sleep = 1'b0;
    logic          gclk;

    int checks = 0;
    int errors = 0;
    int scnt [NS];

    gclk_gen #(.N_SRC(NS), .DIV_W(8)) u_gclk_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_lvl_i    (src),
        .cfg_en_i     (en),
        .cfg_sel_i    (sel),
        .cfg_div_en_i (div_en),
        .cfg_div_i    (div),
        .sleep_off_i  (sleep),
        .gclk_o       (gclk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // source k toggles every k+1 sampling cycles, on the falling edge
    always @(negedge clk) begin
        for (int k = 0; k < NS; k++) begin
            scnt[k] = scnt[k] + 1;
            if (scnt[k] >= k + 1) begin
                scnt[k] = 0;
                src[k] <= ~src[k];
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_out(input logic v, input int lim, input string req);
        int n = 0;
        while (gclk !== v && n < lim) begin
            tick();
            n++;
        end
        if (gclk !== v) check(1'b0, req, int'(gclk), int'(v));
    endtask

    task automatic phase_len(input logic v, output int w);
        w = 0;
        while (gclk === v && w < 4000) begin
            tick();
            w++;
        end
    endtask

    task automatic stop_chan();
        en = 1'b0;
        wait_out(1'b0, 4000, "stop");
        repeat (3) tick();
    endtask

    task automatic hold_low(input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (gclk !== 1'b0) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        for (int k = 0; k < NS; k++) scnt[k] = 0;
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int w;
        int w2;
        int bad;
        int rises;
        logic prev;

        // R1: low during reset
        repeat (3) tick();
        check(gclk === 1'b0, "R1 in reset", int'(gclk), 0);
        rst_n = 1'b1;
        // R1: low after reset while not yet enabled
        hold_low(20, "R1 after reset");

        // table of divided configurations (R3)
        for (int i = 0; i < 6; i++) begin
            stop_chan();
            sel = VECS[i].sel;
            div = VECS[i].div;
            div_en = 1'b1;
            en = 1'b1;
            wait_out(1'b1, 4000, "R3 start");
            phase_len(1'b1, w);
            phase_len(1'b0, w2);
            check(w == int'(VECS[i].width), "R3 high phase", w, int'(VECS[i].width));
            check(w2 == int'(VECS[i].width), "R3 low phase", w2, int'(VECS[i].width));
        end

        // R4: maximum ratio 512 on source 0 (period 2)
        stop_chan();
        sel = 2'd0; div = 8'd255; div_en = 1'b1; en = 1'b1;
        wait_out(1'b1, 4000, "R4 start");
        phase_len(1'b1, w);
        phase_len(1'b0, w2);
        check(w == 512, "R4 high phase", w, 512);
        check(w2 == 512, "R4 low phase", w2, 512);

        // R2: pass mode follows source 1 one cycle later
        stop_chan();
        sel = 2'd1; div_en = 1'b0; en = 1'b1;
        repeat (2) tick();
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (gclk !== src[1]) bad++;
        end
        check(bad == 0, "R2 pass follows source", bad, 0);

        // R9: disabled output stays low
        stop_chan();
        hold_low(60, "R9 disabled low");

        // R6: disabling during a high phase keeps it full length
        sel = 2'd0; div = 8'd3; div_en = 1'b1; en = 1'b1;
        wait_out(1'b1, 4000, "R6 start");
        en = 1'b0;
        phase_len(1'b1, w);
        check(w == 8, "R6 high not cut", w, 8);
        hold_low(60, "R6 stays low after stop");

        // R5: sleep request stops the channel at the low phase
        en = 1'b1;
        wait_out(1'b1, 4000, "R5 start");
        sleep = 1'b1;
        phase_len(1'b1, w);
        check(w == 8, "R5 high not cut", w, 8);
        hold_low(60, "R5 sleep low");
        sleep = 1'b0;
        wait_out(1'b1, 4000, "R5 resume");
        check(gclk === 1'b1, "R5 resumes", int'(gclk), 1);

        // R7: select change while running is ignored
        stop_chan();
        sel = 2'd0; div = 8'd1; div_en = 1'b1; en = 1'b1;
        wait_out(1'b1, 4000, "R7 start");
        sel = 2'd2;
        phase_len(1'b1, w);
        phase_len(1'b0, w2);
        check(w == 4, "R7 high with old source", w, 4);
        check(w2 == 4, "R7 low with old source", w2, 4);
        stop_chan();
        en = 1'b1;
        wait_out(1'b1, 4000, "R7 restart");
        phase_len(1'b1, w);
        check(w == 12, "R7 new source after restart", w, 12);

        // R8: counter cleared by a stop in mid low phase
        stop_chan();
        sel = 2'd0; div = 8'd3; div_en = 1'b1; en = 1'b1;
        wait_out(1'b1, 4000, "R8 start");
        wait_out(1'b0, 4000, "R8 fall");
        repeat (4) tick();
        en = 1'b0;
        repeat (3) tick();
        check(gclk === 1'b0, "R8 stopped low", int'(gclk), 0);
        en = 1'b1;
        tick();
        prev = src[0];
        rises = 0;
        for (int i = 0; i < 100 && gclk !== 1'b1; i++) begin
            tick();
            if (src[0] && !prev) rises++;
            prev = src[0];
        end
        check(rises == 4, "R8 full first period", rises, 4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule